// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

This block is an eight-stage synchronous down counter whose counting code is fixed at elaboration time. In binary form the stages count as one 8-bit value from 255 to 0. In decimal form they are two packed BCD decades that count from 99 to 00. While enabled, the count drops by one on each rising clock edge. A zero count wraps to the full-scale value. Every control input is active-low. Clearing the counter sets it to full scale, not to zero. A jam word can be loaded either at the next rising edge or at once, with no clock edge.

The active-low carry-out/zero-detect output goes low only while the count is zero and the carry-in/enable input is low. This lets counters be chained into wider counters. The carry-out of one stage drives the carry-in of the next. The upper stage then steps once for each full cycle of the lower stage and still takes its own synchronous jam value.

Top module: `preset_down_counter`

## Requirements
- R1: When `cen_n` is low and the preset and clear inputs are high, each rising edge of `clk` lowers `count` by exactly one in the selected code.
- R2: While `cen_n` is high and no preset or clear input is asserted, `count` keeps its value across clock edges.
- R3: When `sload_n` is low at a rising edge, `count` takes `jam` on that edge, whether `cen_n` is high or low.
- R4: While `aload_n` is low, `count` follows `jam` with no clock edge needed. This load takes priority over `sload_n` and counting.
- R5: While `clr_n` is low, `count` is held at full scale (0xFF binary, 0x99 decimal) with no clock edge needed, whatever the other inputs do.
- R6: `tc_n` is low exactly when `count` is zero and `cen_n` is low, and high otherwise.
- R7: An enabled decrement from zero gives full scale (0xFF binary, 0x99 decimal).
- R8: With `DECIMAL` = 1, bits 3:0 of `count` hold the units decade and bits 7:4 the tens decade. Units pass from 0 to 9 while tens drop by one, and a valid code stays valid.
- R9: With `DECIMAL` = 1, a decade above 9 loaded by a jam is not corrected. It drops by one per enabled edge until it reaches a valid digit.
- R10: Two counters whose upper `cen_n` is driven by the lower `tc_n` count as one 16-bit binary counter, or as one 4-digit BCD counter (lower stage in bits 7:0). The upper `tc_n` is low only when the whole chained value is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear to full scale, active-low |
| cen_n | input | 1 | Carry-in / count enable, active-low |
| sload_n | input | 1 | Synchronous jam load, active-low |
| aload_n | input | 1 | Asynchronous jam load, active-low |
| jam | input | STAGES | Preset value |
| count | output | STAGES | Current count |
| tc_n | output | 1 | Carry-out / zero-detect, active-low |

## Verification
The bench builds the default 8-stage width in both binary and decimal form, side by side. It also builds a chained pair in each form. At this width the full counting range fits in a few hundred cycles. A sweep can therefore walk through every binary state and every decimal state, including the wrap from zero. The chained pairs run more than five hundred cycles. This carries them through several borrows into the upper stage and through the wrap of the whole 16-bit or 4-digit value.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // Width of one decimal decade in the BCD variant.
    localparam int DIGIT_W = 4;

    // Full-scale count for a given number of stages and code:
    // all ones in binary, the digit 9 in each decade in decimal.
    function automatic logic [63:0] full_scale(int stages, bit decimal);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < stages) begin
                v[i] = decimal ? (((i % DIGIT_W) == 0) || ((i % DIGIT_W) == 3)) : 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/pdc_decade_step.sv
// pdc_decade_step
// One BCD decade of the decimal decrementer. When a borrow arrives the digit
// drops by one, and a zero digit becomes 9 and passes the borrow upward.
// Assumes: codes above 9 are not corrected; they simply drop by one.
module pdc_decade_step #(
    parameter int W = 4
) (
    input  logic [W-1:0] digit_i,
    input  logic         borrow_i,
    output logic [W-1:0] digit_o,
    output logic         borrow_o
);

    // Decrement this decade when a borrow arrives from below.
    always_comb begin
        digit_o  = digit_i;
        borrow_o = 1'b0;
        if (borrow_i) begin
            if (digit_i == '0) begin
                digit_o  = W'(9);
                borrow_o = 1'b1;
            end else begin
                digit_o  = digit_i - W'(1);
            end
        end
    end

endmodule

// File: rtl/pdc_next_count.sv
// pdc_next_count
// Works out the value the count register takes at the next rising edge:
// a synchronous jam load (which ignores the enable), an enabled decrement
// in the chosen code, or a hold. It also flags a zero count for the
// carry-out logic.
// Assumes: STAGES is a multiple of DIGIT_W when DECIMAL is set.
module pdc_next_count
    import pdc_pkg::*;
#(
    parameter int STAGES  = 8,
    parameter bit DECIMAL = 1'b0
) (
    input  logic [STAGES-1:0] cur_i,
    input  logic [STAGES-1:0] jam_i,
    input  logic              sload_n_i,
    input  logic              cen_n_i,
    output logic [STAGES-1:0] nxt_o,
    output logic              is_zero_o
);

    localparam int NDIG = STAGES / DIGIT_W;

    logic [STAGES-1:0] dec_val;

    generate
        if (DECIMAL) begin : g_bcd
            logic [NDIG:0] borrow;
            assign borrow[0] = 1'b1;
            for (genvar d = 0; d < NDIG; d++) begin : g_digit
                pdc_decade_step #(.W(DIGIT_W)) u_digit (
                    .digit_i  (cur_i[d*DIGIT_W +: DIGIT_W]),
                    .borrow_i (borrow[d]),
                    .digit_o  (dec_val[d*DIGIT_W +: DIGIT_W]),
                    .borrow_o (borrow[d+1])
                );
            end
            // A borrow leaves the top decade only when every decade is zero.
            assign is_zero_o = borrow[NDIG];
        end else begin : g_bin
            assign dec_val   = cur_i - STAGES'(1);
            assign is_zero_o = ~|cur_i;
        end
    endgenerate

    // Choose the edge-time source: jam load, then decrement, then hold.
    always_comb begin
        if (!sload_n_i) begin
            nxt_o = jam_i;
        end else if (!cen_n_i) begin
            nxt_o = dec_val;
        end else begin
            nxt_o = cur_i;
        end
    end

endmodule

// File: rtl/pdc_carry_out.sv
// pdc_carry_out
// Active-low carry-out/zero-detect. It is low only while the count is zero
// and carry-in is asserted, so a chained upper stage steps once per wrap
// of the lower stage.
// Assumes: is_zero_i comes straight from the present count (no register).
module pdc_carry_out (
    input  logic is_zero_i,
    input  logic cen_n_i,
    output logic tc_n_o
);

    // Gate zero detection with the carry-in.
    always_comb begin
        tc_n_o = ~(is_zero_i & ~cen_n_i);
    end

endmodule

// File: rtl/preset_down_counter.sv
// preset_down_counter
// Presettable down counter with STAGES bits, in binary or packed BCD
// (DECIMAL). Priority: clear to full scale (asynchronous), then
// asynchronous jam load, then synchronous jam load, then counting.
// Assumes: jam is held steady while aload_n is low. Releasing clr_n while
// aload_n is still low leaves full scale in place until the next edge.
module preset_down_counter
    import pdc_pkg::*;
#(
    parameter int STAGES  = 8,
    parameter bit DECIMAL = 1'b0
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              cen_n,
    input  logic              sload_n,
    input  logic              aload_n,
    input  logic [STAGES-1:0] jam,
    output logic [STAGES-1:0] count,
    output logic              tc_n
);

    localparam logic [63:0]       FS_WIDE = full_scale(STAGES, DECIMAL);
    localparam logic [STAGES-1:0] MAX_CNT = FS_WIDE[STAGES-1:0];

    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] cnt_d;
    logic              cnt_zero;

    pdc_next_count #(
        .STAGES  (STAGES),
        .DECIMAL (DECIMAL)
    ) u_next (
        .cur_i     (cnt_q),
        .jam_i     (jam),
        .sload_n_i (sload_n),
        .cen_n_i   (cen_n),
        .nxt_o     (cnt_d),
        .is_zero_o (cnt_zero)
    );

    pdc_carry_out u_carry (
        .is_zero_i (cnt_zero),
        .cen_n_i   (cen_n),
        .tc_n_o    (tc_n)
    );

    // Count register with asynchronous clear and asynchronous jam load.
    always_ff @(posedge clk or negedge clr_n or negedge aload_n) begin
        if (!clr_n) begin
            cnt_q <= MAX_CNT;
        end else if (!aload_n) begin
            cnt_q <= jam;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/preset_down_counter_chk.sv
// preset_down_counter_chk
// Temporal checks on the counter ports, attached to every instance by bind.
// Assumes: asynchronous loads are only pulsed while sload_n was low at the
// previous edge, so edge-sampled properties see every change of count.
module preset_down_counter_chk
    import pdc_pkg::*;
#(
    parameter int STAGES  = 8,
    parameter bit DECIMAL = 1'b0
) (
    input logic              clk,
    input logic              clr_n,
    input logic              cen_n,
    input logic              sload_n,
    input logic              aload_n,
    input logic [STAGES-1:0] jam,
    input logic [STAGES-1:0] count,
    input logic              tc_n
);

    localparam logic [63:0]       FS_CHK  = full_scale(STAGES, DECIMAL);
    localparam logic [STAGES-1:0] TOP_CNT = FS_CHK[STAGES-1:0];
    localparam int                NDIG    = STAGES / DIGIT_W;

    // Set one edge after clear is released, so $past never reaches into reset.
    logic armed;
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    function automatic bit digits_ok(logic [STAGES-1:0] v);
        for (int d = 0; d < NDIG; d++) begin
            if (v[d*DIGIT_W +: DIGIT_W] > DIGIT_W'(9)) begin
                return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    generate
        if (!DECIMAL) begin : g_bin_chk
            // R1
            step_by_one_chk: assert property (@(posedge clk) disable iff (!clr_n)
                (armed && $past(!cen_n && sload_n && aload_n) && aload_n)
                |-> count == $past(count) - STAGES'(1));
        end else begin : g_bcd_chk
            // R8
            decade_valid_chk: assert property (@(posedge clk) disable iff (!clr_n)
                (armed && $past(!cen_n && sload_n && aload_n && digits_ok(count)) && aload_n)
                |-> digits_ok(count));
        end
    endgenerate

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (armed && $past(cen_n && sload_n && aload_n) && aload_n)
        |-> $stable(count));

    // R3
    sync_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (armed && $past(!sload_n && aload_n) && aload_n)
        |-> count == $past(jam));

    // R5
    clear_max_chk: assert property (@(posedge clk)
        !clr_n |-> count == TOP_CNT);

    // R6
    zero_low_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (count == '0 && !cen_n) |-> !tc_n);

    // R6
    carry_cause_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !tc_n |-> (count == '0 && !cen_n));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (armed && $past(count == '0 && !cen_n && sload_n && aload_n) && aload_n)
        |-> count == TOP_CNT);

endmodule

bind preset_down_counter preset_down_counter_chk #(
    .STAGES  (STAGES),
    .DECIMAL (DECIMAL)
) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .cen_n   (cen_n),
    .sload_n (sload_n),
    .aload_n (aload_n),
    .jam     (jam),
    .count   (count),
    .tc_n    (tc_n)
);

// File: tb/preset_down_counter_bench.sv
module preset_down_counter_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       clr_n   = 1'b1;
    logic       cen_n   = 1'b1;
    logic       sload_n = 1'b1;
    logic       aload_n = 1'b1;
    logic [7:0] jam     = 8'h00;
    logic [7:0] b_count, d_count;
    logic       b_tc_n, d_tc_n;

    logic        ch_cen_n   = 1'b1;
    logic        ch_sload_n = 1'b1;
    logic [15:0] cb_jam     = 16'h0000;
    logic [15:0] cd_jam     = 16'h0000;
    logic [7:0]  cb_lo_q, cb_hi_q, cd_lo_q, cd_hi_q;
    logic        cb_lo_tc, cb_hi_tc, cd_lo_tc, cd_hi_tc;

    int n_run  = 0;
    int n_fail = 0;

    preset_down_counter #(.STAGES(8), .DECIMAL(1'b0)) u_preset_down_counter (
        .clk(clk), .clr_n(clr_n), .cen_n(cen_n), .sload_n(sload_n),
        .aload_n(aload_n), .jam(jam), .count(b_count), .tc_n(b_tc_n));

    preset_down_counter #(.STAGES(8), .DECIMAL(1'b1)) u_bcd (
        .clk(clk), .clr_n(clr_n), .cen_n(cen_n), .sload_n(sload_n),
        .aload_n(aload_n), .jam(jam), .count(d_count), .tc_n(d_tc_n));

    preset_down_counter #(.STAGES(8), .DECIMAL(1'b0)) u_cb_lo (
        .clk(clk), .clr_n(clr_n), .cen_n(ch_cen_n), .sload_n(ch_sload_n),
        .aload_n(1'b1), .jam(cb_jam[7:0]), .count(cb_lo_q), .tc_n(cb_lo_tc));

    preset_down_counter #(.STAGES(8), .DECIMAL(1'b0)) u_cb_hi (
        .clk(clk), .clr_n(clr_n), .cen_n(cb_lo_tc), .sload_n(ch_sload_n),
        .aload_n(1'b1), .jam(cb_jam[15:8]), .count(cb_hi_q), .tc_n(cb_hi_tc));

    preset_down_counter #(.STAGES(8), .DECIMAL(1'b1)) u_cd_lo (
        .clk(clk), .clr_n(clr_n), .cen_n(ch_cen_n), .sload_n(ch_sload_n),
        .aload_n(1'b1), .jam(cd_jam[7:0]), .count(cd_lo_q), .tc_n(cd_lo_tc));

    preset_down_counter #(.STAGES(8), .DECIMAL(1'b1)) u_cd_hi (
        .clk(clk), .clr_n(clr_n), .cen_n(cd_lo_tc), .sload_n(ch_sload_n),
        .aload_n(1'b1), .jam(cd_jam[15:8]), .count(cd_hi_q), .tc_n(cd_hi_tc));

    function automatic logic [7:0] bcd_next(logic [7:0] v);
        if (v[3:0] != 4'd0) return {v[7:4], v[3:0] - 4'd1};
        return {(v[7:4] != 4'd0) ? v[7:4] - 4'd1 : 4'd9, 4'd9};
    endfunction

    function automatic logic [15:0] bcd4_next(logic [15:0] v);
        int n;
        logic [15:0] r;
        n = 0;
        for (int d = 3; d >= 0; d--) n = n * 10 + int'(v[d*4 +: 4]);
        n = (n + 9999) % 10000;
        for (int d = 0; d < 4; d++) begin
            r[d*4 +: 4] = 4'(n % 10);
            n = n / 10;
        end
        return r;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin : watchdog
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0]  exp_b, exp_d;
        logic [15:0] exp_cb, exp_cd;
        #1 clr_n = 1'b0;
        tick();
        tick();
        // R5: reset state is full scale in each code
        check("R5 binary reset", b_count, 16'h00FF);
        check("R5 decimal reset", d_count, 16'h0099);
        check("R6 tc_n idle", {b_tc_n, d_tc_n}, 16'h0003);
        clr_n = 1'b1;
        tick();
        check("R2 hold after clear", b_count, 16'h00FF);

        // R1 R7 R8: full sweep of both codes including wrap
        cen_n = 1'b0;
        #1;
        check("R6 nonzero tc_n", {b_tc_n, d_tc_n}, 16'h0003);
        exp_b = 8'hFF;
        exp_d = 8'h99;
        for (int i = 0; i < 260; i++) begin
            string rb, rd;
            rb = (exp_b == 8'h00) ? "R7 binary wrap" : "R1 binary step";
            rd = (exp_d == 8'h00) ? "R7 decimal wrap" : "R8 decimal step";
            tick();
            exp_b = exp_b - 8'd1;
            exp_d = bcd_next(exp_d);
            check(rb, b_count, exp_b);
            check(rd, d_count, exp_d);
            check("R6 binary tc_n", b_tc_n, (exp_b == 8'h00) ? 16'h0 : 16'h1);
            check("R6 decimal tc_n", d_tc_n, (exp_d == 8'h00) ? 16'h0 : 16'h1);
        end

        // R2: hold while disabled
        cen_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R2 binary hold", b_count, exp_b);
            check("R2 decimal hold", d_count, exp_d);
        end

        // R3: sync load with enable off; R6 zero gated by carry-in
        jam = 8'h00;
        sload_n = 1'b0;
        tick();
        check("R3 load disabled", {b_count, d_count}, 16'h0000);
        check("R6 zero but carry-in high", {b_tc_n, d_tc_n}, 16'h0003);
        sload_n = 1'b1;
        cen_n = 1'b0;
        #1;
        check("R6 zero with carry-in low", {b_tc_n, d_tc_n}, 16'h0000);

        // R3: sync load wins over counting
        jam = 8'h47;
        sload_n = 1'b0;
        tick();
        check("R3 load enabled", {b_count, d_count}, 16'h4747);

        // R9: invalid decade recovers by plain decrement
        jam = 8'hAF;
        tick();
        sload_n = 1'b0;
        check("R3 load AF", {b_count, d_count}, 16'hAFAF);
        sload_n = 1'b1;
        exp_b = 8'hAF;
        exp_d = 8'hAF;
        for (int i = 0; i < 25; i++) begin
            tick();
            exp_b = exp_b - 8'd1;
            exp_d = bcd_next(exp_d);
            check("R9 invalid decade", d_count, exp_d);
            check("R1 binary step", b_count, exp_b);
        end

        // R4: asynchronous load, no edge needed
        cen_n = 1'b1;
        jam = 8'h3C;
        sload_n = 1'b0;
        tick();
        check("R3 load 3C", {b_count, d_count}, 16'h3C3C);
        jam = 8'h81;
        aload_n = 1'b0;
        #1;
        check("R4 async load", {b_count, d_count}, 16'h8181);
        tick();
        check("R4 async held through edge", {b_count, d_count}, 16'h8181);
        aload_n = 1'b1;
        tick();
        check("R4 after release", {b_count, d_count}, 16'h8181);

        // R5: clear beats asynchronous load, without an edge
        jam = 8'h12;
        tick();
        check("R3 load 12", {b_count, d_count}, 16'h1212);
        clr_n = 1'b0;
        #1;
        check("R5 async clear", {b_count, d_count}, 16'hFF99);
        aload_n = 1'b0;
        #1;
        check("R5 clear over preset", {b_count, d_count}, 16'hFF99);
        aload_n = 1'b1;
        clr_n = 1'b1;
        #1;
        check("R5 released no edge", {b_count, d_count}, 16'hFF99);
        tick();
        check("R3 load after clear", {b_count, d_count}, 16'h1212);
        sload_n = 1'b1;

        // R10: chained pairs as 16-bit binary and 4-digit BCD
        cb_jam = 16'h0203;
        cd_jam = 16'h0105;
        ch_sload_n = 1'b0;
        tick();
        check("R10 chain binary load", {cb_hi_q, cb_lo_q}, 16'h0203);
        check("R10 chain decimal load", {cd_hi_q, cd_lo_q}, 16'h0105);
        ch_sload_n = 1'b1;
        ch_cen_n = 1'b0;
        exp_cb = 16'h0203;
        exp_cd = 16'h0105;
        for (int i = 0; i < 530; i++) begin
            tick();
            exp_cb = exp_cb - 16'd1;
            exp_cd = bcd4_next(exp_cd);
            check("R10 chain binary", {cb_hi_q, cb_lo_q}, exp_cb);
            check("R10 chain decimal", {cd_hi_q, cd_lo_q}, exp_cd);
            check("R10 chain binary carry", cb_hi_tc, (exp_cb == 16'h0) ? 16'h0 : 16'h1);
            check("R10 chain decimal carry", cd_hi_tc, (exp_cd == 16'h0) ? 16'h0 : 16'h1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule